// File: doc/BRIEF.md
# Pipeline Hazard and Redirect Control

This block steers the front half of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) that has no branch delay slots. It looks at the instruction held in decode and the instructions held in the three later stages. From them it decides whether decode must wait for a register value that has not yet been written. It also picks where the next fetch address comes from and whether each front instruction register takes a new word, keeps its word or is squashed to a bubble. Jumps are recognised in decode, so the one instruction fetched behind a jump is discarded. Conditional branches are resolved in execute with the ALU zero flag. A taken branch discards the two younger instructions.

A small shell holds the program counter and the four instruction registers, so the effect of every decision can be seen at the ports. The surrounding datapath supplies the fetched word, the three candidate targets (absolute, register-indirect and branch) and the zero flag for the instruction in execute. Operand forwarding, exceptions and memory wait states are not part of this block. Whenever decode and execute ask for different things, the older instruction in execute wins.

Top module: `pipe_ctrl`

## Requirements
- R1: Instruction words are 32 bits: opcode [31:28], first source [27:23], second source [22:18], destination [17:13], write enable [12], first read enable [11], second read enable [10]. `stall` is high when decode's first read enable is set and its first source equals the destination of the execute, memory or writeback instruction whose write enable is set.
- R2: `stall` is likewise high when decode's second read enable is set and its second source matches an enabled destination in execute, memory or writeback.
- R3: A source specifier of 0 never raises `stall`.
- R4: Opcode 5 is branch-if-zero and opcode 6 is branch-if-nonzero. The branch is taken when execute holds opcode 5 with `alu_zero` high, or opcode 6 with `alu_zero` low. While execute holds a taken branch, `stall` is low.
- R5: `pc_sel` (0 sequential, 1 absolute, 2 register-indirect, 3 branch) follows this priority: a taken branch gives 3. Otherwise decode opcode 1 or 2 (jump, jump-and-link) gives 1. Otherwise decode opcode 3 or 4 (jump-register, jump-register-and-link) gives 2. Otherwise it gives 0.
- R6: `pc` resets to 0. Each cycle it loads the target chosen by `pc_sel` (pc+4, `abs_target`, `ind_target`, `br_target`), except that it holds its value while `stall` is high.
- R7: `dec_sel` (0 fetched, 1 hold, 2 bubble) is 2 on a taken branch. Otherwise it is 1 while stalled, otherwise 2 when decode holds any jump (opcodes 1 to 4), otherwise 0. `ir_d` updates accordingly on the next edge.
- R8: `exe_sel` (0 from decode, 2 bubble) is 2 on a taken branch or while stalled, and 0 otherwise. `ir_e` updates accordingly.
- R9: `ir_m` takes `ir_e`, and `ir_w` takes `ir_m`, on every edge.
- R10: While `rst_n` is low, `pc` is 0 and all four instruction registers hold the all-zero bubble word.
- R11: A jump leaves exactly one bubble behind it and a taken branch leaves two. An untaken branch costs nothing: the next two instructions follow it without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| fetch_word | input | 32 | Instruction word read at `pc` |
| abs_target | input | PC_W | Absolute jump target for the decode instruction |
| ind_target | input | PC_W | Register value for an indirect jump in decode |
| br_target | input | PC_W | Branch target for the execute instruction |
| alu_zero | input | 1 | Zero flag for the execute instruction |
| stall | output | 1 | Decode waits on a pending register write |
| pc_sel | output | 2 | Next fetch address source |
| dec_sel | output | 2 | Decode register source |
| exe_sel | output | 2 | Execute register source |
| pc | output | PC_W | Program counter |
| ir_d | output | 32 | Decode instruction register |
| ir_e | output | 32 | Execute instruction register |
| ir_m | output | 32 | Memory instruction register |
| ir_w | output | 32 | Writeback instruction register |

## Verification
The hardest cases to reach are a pending stall that meets a taken branch in the same cycle, and a jump-register that is held in decode by its own operand hazard. Both require a specific mix of older instructions to be in flight at once. The stimulus feeds a long stream of instructions drawn from a four-register pool, with random read and write enables and a random zero flag, so that register collisions, branches in execute and jumps in decode overlap often. A behavioural model follows every cycle. Directed sequences after a flush count the bubbles left behind by a jump, a taken branch and an untaken branch.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 4;
  localparam int REG_W   = 5;

  // field positions inside an instruction word
  localparam int OP_LSB  = 28;
  localparam int RS_LSB  = 23;
  localparam int RT_LSB  = 18;
  localparam int WS_LSB  = 13;
  localparam int WE_BIT  = 12;
  localparam int RE1_BIT = 11;
  localparam int RE2_BIT = 10;

  localparam logic [INSTR_W-1:0] BUBBLE = '0;

  typedef enum logic [OP_W-1:0] {
    OPC_ALU  = 4'd0,
    OPC_J    = 4'd1,
    OPC_JAL  = 4'd2,
    OPC_JR   = 4'd3,
    OPC_JALR = 4'd4,
    OPC_BEQZ = 4'd5,
    OPC_BNEZ = 4'd6
  } opc_e;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_ABS = 2'd1,
    NPC_IND = 2'd2,
    NPC_BR  = 2'd3
  } npc_sel_e;

  typedef enum logic [1:0] {
    IRS_LOAD = 2'd0,
    IRS_HOLD = 2'd1,
    IRS_KILL = 2'd2
  } ir_sel_e;

  function automatic logic [OP_W-1:0] f_op(input logic [INSTR_W-1:0] w);
    return w[OP_LSB +: OP_W];
  endfunction

  function automatic logic [REG_W-1:0] f_rs(input logic [INSTR_W-1:0] w);
    return w[RS_LSB +: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] f_rt(input logic [INSTR_W-1:0] w);
    return w[RT_LSB +: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] f_ws(input logic [INSTR_W-1:0] w);
    return w[WS_LSB +: REG_W];
  endfunction

endpackage

// File: rtl/pc_hazard_detect.sv
module pc_hazard_detect
  import pipe_ctrl_pkg::*;
#(
  parameter int N_WSTAGE = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [INSTR_W-1:0]                dec_word,
  input  logic [N_WSTAGE-1:0][INSTR_W-1:0]  wr_words,
  input  logic                              br_taken,
  output logic                              stall
);

  logic [REG_W-1:0]    src_a, src_b;
  logic                use_a, use_b;
  logic [N_WSTAGE-1:0] hit_a, hit_b;
  logic                raw_stall;

  assign src_a = f_rs(dec_word);
  assign src_b = f_rt(dec_word);
  assign use_a = dec_word[RE1_BIT] && (src_a != '0);
  assign use_b = dec_word[RE2_BIT] && (src_b != '0);

  for (genvar s = 0; s < N_WSTAGE; s++) begin : g_cmp
    logic             wen;
    logic [REG_W-1:0] dst;
    assign wen      = wr_words[s][WE_BIT];
    assign dst      = f_ws(wr_words[s]);
    assign hit_a[s] = use_a && wen && (dst == src_a);
    assign hit_b[s] = use_b && wen && (dst == src_b);
  end

  assign raw_stall = (|hit_a) || (|hit_b);

  always_comb begin
    stall = raw_stall;
    if (br_taken) stall = 1'b0;
  end

  // wrong-path decode never holds the pipe
  assert_no_stall_on_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> !stall);

  assert_zero_src_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (f_rs(dec_word) == '0 && f_rt(dec_word) == '0) |-> !stall);

  assert_unread_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_word[RE1_BIT] && !dec_word[RE2_BIT]) |-> !stall);

endmodule

// File: rtl/pc_redirect_ctrl.sv
module pc_redirect_ctrl
  import pipe_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] dec_word,
  input  logic [INSTR_W-1:0] exe_word,
  input  logic               alu_zero,
  input  logic               stall,
  output logic               br_taken,
  output npc_sel_e           npc_sel,
  output ir_sel_e            dsel,
  output ir_sel_e            esel
);

  logic [OP_W-1:0] dop, eop;
  logic            dec_abs, dec_ind, dec_jump;

  assign dop = f_op(dec_word);
  assign eop = f_op(exe_word);

  always_comb begin
    br_taken = 1'b0;
    if (eop == OPC_BEQZ && alu_zero)  br_taken = 1'b1;
    if (eop == OPC_BNEZ && !alu_zero) br_taken = 1'b1;
  end

  assign dec_abs  = (dop == OPC_J)  || (dop == OPC_JAL);
  assign dec_ind  = (dop == OPC_JR) || (dop == OPC_JALR);
  assign dec_jump = dec_abs || dec_ind;

  // older instruction in execute has priority over decode
  always_comb begin
    if (br_taken)     npc_sel = NPC_BR;
    else if (dec_abs) npc_sel = NPC_ABS;
    else if (dec_ind) npc_sel = NPC_IND;
    else              npc_sel = NPC_SEQ;
  end

  always_comb begin
    if (br_taken)      dsel = IRS_KILL;
    else if (stall)    dsel = IRS_HOLD;
    else if (dec_jump) dsel = IRS_KILL;
    else               dsel = IRS_LOAD;
  end

  always_comb begin
    if (br_taken || stall) esel = IRS_KILL;
    else                   esel = IRS_LOAD;
  end

  assert_taken_picks_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (npc_sel == NPC_BR && dsel == IRS_KILL && esel == IRS_KILL));

  assert_stall_bubbles_exe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (esel == IRS_KILL && dsel == IRS_HOLD));

endmodule

// File: rtl/pc_stage_regs.sv
module pc_stage_regs
  import pipe_ctrl_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] fetch_word,
  input  logic [PC_W-1:0]    abs_target,
  input  logic [PC_W-1:0]    ind_target,
  input  logic [PC_W-1:0]    br_target,
  input  logic               stall,
  input  npc_sel_e           npc_sel,
  input  ir_sel_e            dsel,
  input  ir_sel_e            esel,
  output logic [PC_W-1:0]    pc_q,
  output logic [INSTR_W-1:0] ird_q,
  output logic [INSTR_W-1:0] ire_q,
  output logic [INSTR_W-1:0] irm_q,
  output logic [INSTR_W-1:0] irw_q
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0]    pc_d;
  logic               pc_en;
  logic [INSTR_W-1:0] ird_d, ire_d;

  always_comb begin
    unique case (npc_sel)
      NPC_ABS: pc_d = abs_target;
      NPC_IND: pc_d = ind_target;
      NPC_BR:  pc_d = br_target;
      default: pc_d = pc_q + STEP;
    endcase
  end

  // a taken branch already forces stall low, so stall alone gates the PC
  assign pc_en = !stall;

  always_comb begin
    unique case (dsel)
      IRS_HOLD: ird_d = ird_q;
      IRS_KILL: ird_d = BUBBLE;
      default:  ird_d = fetch_word;
    endcase
  end

  always_comb begin
    if (esel == IRS_KILL) ire_d = BUBBLE;
    else                  ire_d = ird_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ird_q <= BUBBLE;
      ire_q <= BUBBLE;
      irm_q <= BUBBLE;
      irw_q <= BUBBLE;
    end else begin
      ird_q <= ird_d;
      ire_q <= ire_d;
      irm_q <= ire_q;
      irw_q <= irm_q;
    end
  end

  assert_pc_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc_q));

  assert_bubble_after_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (esel == IRS_KILL) |=> (ire_q == BUBBLE));

  assert_kill_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsel == IRS_KILL) |=> (ird_q == BUBBLE));

  assert_tail_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irm_q == $past(ire_q) && irw_q == $past(irm_q)));

endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import pipe_ctrl_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        fetch_word,
  input  logic [PC_W-1:0]    abs_target,
  input  logic [PC_W-1:0]    ind_target,
  input  logic [PC_W-1:0]    br_target,
  input  logic               alu_zero,
  output logic               stall,
  output logic [1:0]         pc_sel,
  output logic [1:0]         dec_sel,
  output logic [1:0]         exe_sel,
  output logic [PC_W-1:0]    pc,
  output logic [31:0]        ir_d,
  output logic [31:0]        ir_e,
  output logic [31:0]        ir_m,
  output logic [31:0]        ir_w
);

  localparam int N_WSTAGE = 3;

  logic                             br_taken;
  npc_sel_e                         npc_sel;
  ir_sel_e                          dsel, esel;
  logic [N_WSTAGE-1:0][INSTR_W-1:0] wr_words;

  assign wr_words = {ir_w, ir_m, ir_e};

  pc_hazard_detect #(.N_WSTAGE(N_WSTAGE)) u_hazard (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_word (ir_d),
    .wr_words (wr_words),
    .br_taken (br_taken),
    .stall    (stall)
  );

  pc_redirect_ctrl u_redirect (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_word (ir_d),
    .exe_word (ir_e),
    .alu_zero (alu_zero),
    .stall    (stall),
    .br_taken (br_taken),
    .npc_sel  (npc_sel),
    .dsel     (dsel),
    .esel     (esel)
  );

  pc_stage_regs #(.PC_W(PC_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_word (fetch_word),
    .abs_target (abs_target),
    .ind_target (ind_target),
    .br_target  (br_target),
    .stall      (stall),
    .npc_sel    (npc_sel),
    .dsel       (dsel),
    .esel       (esel),
    .pc_q       (pc),
    .ird_q      (ir_d),
    .ire_q      (ir_e),
    .irm_q      (ir_m),
    .irw_q      (ir_w)
  );

  assign pc_sel  = npc_sel;
  assign dec_sel = dsel;
  assign exe_sel = esel;

  assert_reset_clean_R10: assert property (@(posedge clk)
    !rst_n |-> (pc == '0 && ir_d == '0 && ir_e == '0 && ir_m == '0 && ir_w == '0));

endmodule

// File: tb/pipe_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_ctrl_bench;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [31:0]     fetch_word;
  logic [PC_W-1:0] abs_target, ind_target, br_target;
  logic            alu_zero;
  logic            stall;
  logic [1:0]      pc_sel, dec_sel, exe_sel;
  logic [PC_W-1:0] pc;
  logic [31:0]     ir_d, ir_e, ir_m, ir_w;

  always #2.5 clk = ~clk;

  pipe_ctrl #(.PC_W(PC_W)) u_pipe_ctrl (.*);

  // reference state: index 0 decode, 1 execute, 2 memory, 3 writeback
  logic [31:0]     ref_ir [4];
  logic [PC_W-1:0] ref_pc;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int rs, input int rt, input int ws,
                                     input bit we, input bit r1, input bit r2);
    logic [31:0] w = '0;
    w[31:28] = 4'(op); w[27:23] = 5'(rs); w[22:18] = 5'(rt); w[17:13] = 5'(ws);
    w[12] = we; w[11] = r1; w[10] = r2;
    return w;
  endfunction

  function automatic bit m_taken(input logic z);
    int op = int'(ref_ir[1][31:28]);
    return (op == 5 && z) || (op == 6 && !z);
  endfunction

  function automatic bit m_stall(input logic z);
    bit hit = 0;
    logic [31:0] d = ref_ir[0];
    for (int s = 1; s < 4; s++) begin
      logic [31:0] w = ref_ir[s];
      if (w[12]) begin
        if (d[11] && d[27:23] != 0 && d[27:23] == w[17:13]) hit = 1;
        if (d[10] && d[22:18] != 0 && d[22:18] == w[17:13]) hit = 1;
      end
    end
    return hit && !m_taken(z);
  endfunction

  function automatic int m_pcsel(input logic z);
    int op = int'(ref_ir[0][31:28]);
    if (m_taken(z)) return 3;
    if (op == 1 || op == 2) return 1;
    if (op == 3 || op == 4) return 2;
    return 0;
  endfunction

  // one cycle: drive, compare at the falling edge, advance model at the rising edge
  task automatic step(input logic [31:0] f, input logic z,
                      input logic [PC_W-1:0] at, input logic [PC_W-1:0] it, input logic [PC_W-1:0] bt);
    bit tk, st; int ps, ds, es; bit jmp;
    fetch_word = f; alu_zero = z; abs_target = at; ind_target = it; br_target = bt;
    @(negedge clk);
    tk = m_taken(z); st = m_stall(z); ps = m_pcsel(z);
    jmp = (ref_ir[0][31:28] >= 1 && ref_ir[0][31:28] <= 4);
    ds = tk ? 2 : st ? 1 : jmp ? 2 : 0;
    es = (tk || st) ? 2 : 0;
    chk("R1/R2/R3/R4 stall", 64'(stall), 64'(st));
    chk("R5 pc_sel", 64'(pc_sel), 64'(ps));
    chk("R7 dec_sel", 64'(dec_sel), 64'(ds));
    chk("R8 exe_sel", 64'(exe_sel), 64'(es));
    chk("R6 pc", 64'(pc), 64'(ref_pc));
    chk("R7 ir_d", 64'(ir_d), 64'(ref_ir[0]));
    chk("R8 ir_e", 64'(ir_e), 64'(ref_ir[1]));
    chk("R9 ir_m", 64'(ir_m), 64'(ref_ir[2]));
    chk("R9 ir_w", 64'(ir_w), 64'(ref_ir[3]));
    @(posedge clk);
    ref_ir[3] = ref_ir[2];
    ref_ir[2] = ref_ir[1];
    if (tk) begin
      ref_pc = bt; ref_ir[0] = '0; ref_ir[1] = '0;
    end else if (st) begin
      ref_ir[1] = '0;
    end else begin
      ref_ir[1] = ref_ir[0];
      ref_ir[0] = jmp ? 32'h0 : f;
      case (ps)
        1: ref_pc = at;
        2: ref_pc = it;
        default: ref_pc = ref_pc + 4;
      endcase
    end
    #1;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(32'h0, 1'b0, 32'h0, 32'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] add1, add2, sub1;
    rst_n = 1'b0; fetch_word = '0; alu_zero = 0;
    abs_target = '0; ind_target = '0; br_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 pc", 64'(pc), 64'h0);
    chk("R10 ir_d", 64'(ir_d), 64'h0);
    chk("R10 ir_e", 64'(ir_e), 64'h0);
    chk("R10 ir_m", 64'(ir_m), 64'h0);
    chk("R10 ir_w", 64'(ir_w), 64'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    ref_pc = '0;
    for (int i = 0; i < 4; i++) ref_ir[i] = '0;

    add1 = mk(0, 7, 8, 9, 1, 1, 1);
    add2 = mk(0, 10, 11, 12, 1, 1, 1);
    sub1 = mk(7, 13, 14, 15, 1, 1, 1);

    // R11: a jump leaves one bubble
    flush();
    step(mk(1, 0, 0, 0, 0, 0, 0), 0, 32'h300, 32'h0, 32'h0);
    step(add1, 0, 32'h300, 32'h0, 32'h0);
    chk("R11 jump kills follower", 64'(ir_d), 64'h0);
    chk("R11 jump target", 64'(pc), 64'h300);
    step(add2, 0, 32'h0, 32'h0, 32'h0);
    chk("R11 jump single bubble", 64'(ir_d), 64'(add2));

    // R11: a taken branch leaves two bubbles
    flush();
    step(mk(5, 20, 0, 0, 0, 1, 0), 0, 32'h0, 32'h0, 32'h0);
    step(add1, 0, 32'h0, 32'h0, 32'h0);
    step(add2, 1, 32'h0, 32'h0, 32'h480);
    chk("R11 branch kills decode", 64'(ir_d), 64'h0);
    chk("R11 branch kills execute", 64'(ir_e), 64'h0);
    chk("R11 branch target", 64'(pc), 64'h480);

    // R11: an untaken branch costs nothing
    flush();
    step(mk(6, 20, 0, 0, 0, 1, 0), 0, 32'h0, 32'h0, 32'h0);
    step(add1, 0, 32'h0, 32'h0, 32'h0);
    step(add2, 1, 32'h0, 32'h0, 32'h480);
    chk("R11 untaken keeps decode", 64'(ir_d), 64'(add2));
    chk("R11 untaken keeps execute", 64'(ir_e), 64'(add1));

    // R1/R3: dependent reads; register 0 never stalls
    flush();
    step(mk(0, 1, 2, 3, 1, 0, 0), 0, 0, 0, 0);
    step(mk(0, 3, 0, 4, 1, 1, 0), 0, 0, 0, 0);
    step(sub1, 0, 0, 0, 0);
    chk("R1 stall on rs match", 64'(stall), 64'h1);
    flush();
    step(mk(0, 1, 2, 0, 1, 0, 0), 0, 0, 0, 0);
    step(mk(0, 0, 0, 4, 1, 1, 1), 0, 0, 0, 0);
    step(sub1, 0, 0, 0, 0);
    chk("R3 zero register quiet", 64'(stall), 64'h0);

    // random mix from a small register pool
    flush();
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 7);
      logic [31:0] w = mk(op, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                          1'($urandom), 1'($urandom), 1'($urandom));
      step(w, 1'($urandom), $urandom, $urandom, $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule